// File: doc/BRIEF.md
# Motor Speed Discriminator and Lock Detector

This block judges how fast a motor turns by timing its frequency-generator (FG) pulse train against a fast reference clock. The FG input is first brought into the reference-clock domain through a two-stage synchronizer. The block then counts reference cycles from one rising FG edge to the next. Each finished count is compared with a target picked by two select pins. The target is the number of reference cycles that one FG period lasts at the wanted speed.

Two active-low flags come out of the comparison. The overspeed flag goes low when the period is shorter than the target, which means the motor is too fast. The lock flag goes low when the period lies within one sixteenth of the target on either side. The measured count is also presented as a bus for observation. All three outputs change once per FG period and hold steady in between.

If the FG input stops, the count saturates instead of wrapping, so a stalled motor never reads as locked. Downstream logic must still tolerate a brief false lock while the motor is starting up.

Top module: `fg_speed_monitor`

## Requirements
- R1: The target count follows the selects (sel_a, sel_b): (1,1) gives 128, (0,1) gives 256, (1,0) gives 512, (0,0) gives 1024.
- R2: After a measurement completes, period_count equals the number of reference clock cycles between the two most recent rising edges of fg_in.
- R3: overspeed_n is 0 when the completed count is below the target, and 1 otherwise.
- R4: lock_n is 0 when the completed count lies in the inclusive range from target - target/16 to target + target/16 (integer division), and 1 outside that range.
- R5: If no rising edge arrives, the running count stops at 2^CNT_W - 1 and does not wrap. A saturated count reports lock_n = 1 and overspeed_n = 1.
- R6: The outputs change only in the cycle that follows a completed measurement. A change of the selects between measurements leaves all outputs unchanged.
- R7: Reset is synchronous and active high. It gives lock_n = 1, overspeed_n = 1 and period_count = 0. The first rising edge after reset only starts a measurement and does not update the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that sets the count rate |
| rst | input | 1 | Synchronous active-high reset |
| fg_in | input | 1 | FG pulse train, asynchronous to clk |
| sel_a | input | 1 | Target select, first bit |
| sel_b | input | 1 | Target select, second bit |
| overspeed_n | output | 1 | Low when the last period was shorter than the target |
| lock_n | output | 1 | Low when the last period was within the ±1/16 window |
| period_count | output | CNT_W | Last completed period count |

## Verification
Two events can fall in the same cycle: a completed measurement and a change of the target selects. A select change that lands between measurements must not move any output. A select change made before the period ends must apply to the whole of that period. The bench changes the selects in the middle of a steady pulse train and confirms that the outputs stay frozen. Every vector then sets its selects before its first edge, so the new target decides the flags of the next completed period. Window edges at target ± target/16, and the counts just outside them, are checked for each of the four targets.

// File: rtl/fg_speed_pkg.sv
package fg_speed_pkg;
  localparam int TGT_W = 11;

  // Target period count picked by the two select pins
  function automatic logic [TGT_W-1:0] target_of(input logic a, input logic b);
    logic [TGT_W-1:0] t;
    unique case ({a, b})
      2'b11:   t = 11'd128;
      2'b01:   t = 11'd256;
      2'b10:   t = 11'd512;
      default: t = 11'd1024;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/fg_edge_sync.sv
module fg_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  localparam int LEN = STAGES + 1;
  logic [LEN-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[LEN-2:0], async_in};
  end

  // Rising edge seen on the synchronized signal
  assign rise = chain[LEN-2] & ~chain[LEN-1];
endmodule

// File: rtl/fg_period_counter.sv
module fg_period_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise,
  output logic [CNT_W-1:0] meas,
  output logic             meas_vld
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt;
  logic             primed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      primed   <= 1'b0;
      meas     <= '0;
      meas_vld <= 1'b0;
    end else begin
      meas_vld <= 1'b0;
      if (rise) begin
        cnt      <= {{(CNT_W-1){1'b0}}, 1'b1};
        primed   <= 1'b1;
        meas     <= cnt;
        meas_vld <= primed;
      end else if (cnt != CNT_MAX) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5: a stalled FG keeps the count pinned at its ceiling
  a_r5_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !rise) |=> (cnt == CNT_MAX));

  // R2: every edge restarts timing from one cycle
  a_r2_restart: assert property (@(posedge clk) disable iff (rst)
    rise |=> (cnt == 1));
endmodule

// File: rtl/fg_speed_judge.sv
module fg_speed_judge #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] meas,
  input  logic             meas_vld,
  input  logic             sel_a,
  input  logic             sel_b,
  output logic             over_n,
  output logic             lock_n,
  output logic [CNT_W-1:0] count_q
);
  import fg_speed_pkg::*;

  localparam int W = CNT_W + 1;
  logic [W-1:0] tgt, lo, hi, m;

  always_comb begin
    tgt = W'(target_of(sel_a, sel_b));
    lo  = tgt - (tgt >> 4);
    hi  = tgt + (tgt >> 4);
    m   = W'(meas);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      over_n  <= 1'b1;
      lock_n  <= 1'b1;
      count_q <= '0;
    end else if (meas_vld) begin
      count_q <= meas;
      over_n  <= ~(m < tgt);
      lock_n  <= ~((m >= lo) && (m <= hi));
    end
  end

  // R6: outputs freeze unless a measurement just completed
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !meas_vld |=> ($stable(over_n) && $stable(lock_n) && $stable(count_q)));

  // R5: a saturated count can never look locked or fast
  a_r5_sat_flags: assert property (@(posedge clk) disable iff (rst)
    (&count_q) |-> (lock_n && over_n));

  // R4: a zero count is never inside any window
  a_r4_zero_unlocked: assert property (@(posedge clk) disable iff (rst)
    (count_q == '0) |-> lock_n);
endmodule

// File: rtl/fg_speed_monitor.sv
module fg_speed_monitor #(
  parameter int CNT_W     = 12,
  parameter int SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fg_in,
  input  logic             sel_a,
  input  logic             sel_b,
  output logic             overspeed_n,
  output logic             lock_n,
  output logic [CNT_W-1:0] period_count
);
  logic             rise;
  logic [CNT_W-1:0] meas;
  logic             meas_vld;

  fg_edge_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst(rst), .async_in(fg_in), .rise(rise)
  );

  fg_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .rise(rise), .meas(meas), .meas_vld(meas_vld)
  );

  fg_speed_judge #(.CNT_W(CNT_W)) u_judge (
    .clk(clk), .rst(rst), .meas(meas), .meas_vld(meas_vld),
    .sel_a(sel_a), .sel_b(sel_b),
    .over_n(overspeed_n), .lock_n(lock_n), .count_q(period_count)
  );

  // R7: a measurement result is never produced in the cycle after reset
  a_r7_no_early_result: assert property (@(posedge clk)
    rst |=> !meas_vld);
endmodule

// File: tb/fg_speed_monitor_tb.sv
module fg_speed_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 12;
  localparam int NV = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fg_in = 1'b0;
  logic sel_a = 1'b1;
  logic sel_b = 1'b1;
  logic overspeed_n, lock_n;
  logic [CNT_W-1:0] period_count;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fg_speed_monitor #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .fg_in(fg_in), .sel_a(sel_a), .sel_b(sel_b),
    .overspeed_n(overspeed_n), .lock_n(lock_n), .period_count(period_count)
  );

  // {sel_a, sel_b, period, expected overspeed_n, expected lock_n}
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b1, 12'd128,  1'b1, 1'b0},
    {1'b1, 1'b1, 12'd120,  1'b0, 1'b0},
    {1'b1, 1'b1, 12'd119,  1'b0, 1'b1},
    {1'b1, 1'b1, 12'd136,  1'b1, 1'b0},
    {1'b1, 1'b1, 12'd137,  1'b1, 1'b1},
    {1'b1, 1'b1, 12'd127,  1'b0, 1'b0},
    {1'b0, 1'b1, 12'd272,  1'b1, 1'b0},
    {1'b0, 1'b1, 12'd239,  1'b0, 1'b1},
    {1'b1, 1'b0, 12'd545,  1'b1, 1'b1},
    {1'b1, 1'b0, 12'd500,  1'b0, 1'b0},
    {1'b0, 1'b0, 12'd1024, 1'b1, 1'b0},
    {1'b0, 1'b0, 12'd959,  1'b0, 1'b1}
  };

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic pulses(input int per, input int n);
    for (int k = 0; k < n; k++) begin
      fg_in = 1'b1;
      repeat (per / 2) @(negedge clk);
      fg_in = 1'b0;
      repeat (per - per / 2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic o0, l0;
    logic [CNT_W-1:0] c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7: reset state
    check("R7 lock_n reset", lock_n, 1);
    check("R7 overspeed_n reset", overspeed_n, 1);
    check("R7 period_count reset", period_count, 0);
    // R7: first edge only starts timing
    fg_in = 1'b1;
    repeat (10) @(negedge clk);
    fg_in = 1'b0;
    repeat (10) @(negedge clk);
    check("R7 first edge count", period_count, 0);
    check("R7 first edge lock_n", lock_n, 1);

    // R1 R2 R3 R4: vector table
    for (int i = 0; i < NV; i++) begin
      sel_a = VEC[i][15];
      sel_b = VEC[i][14];
      pulses(int'(VEC[i][13:2]), 3);
      check($sformatf("R2 count vec%0d", i), period_count, int'(VEC[i][13:2]));
      check($sformatf("R3 R1 overspeed vec%0d", i), overspeed_n, VEC[i][1]);
      check($sformatf("R4 R1 lock vec%0d", i), lock_n, VEC[i][0]);
    end

    // R6: a select change between measurements moves nothing
    o0 = overspeed_n; l0 = lock_n; c0 = period_count;
    sel_a = 1'b1; sel_b = 1'b1;
    repeat (20) @(negedge clk);
    check("R6 hold overspeed_n", overspeed_n, o0);
    check("R6 hold lock_n", lock_n, l0);
    check("R6 hold count", period_count, c0);

    // R6: the new target applies at the next completed period (959 vs 128)
    pulses(959, 3);
    check("R6 new target overspeed_n", overspeed_n, 1);
    check("R6 new target lock_n", lock_n, 1);

    // R5: stalled FG saturates the count
    fg_in = 1'b1;
    @(negedge clk);
    fg_in = 1'b0;
    repeat (4300) @(negedge clk);
    fg_in = 1'b1;
    repeat (20) @(negedge clk);
    fg_in = 1'b0;
    check("R5 saturated count", period_count, 4095);
    check("R5 saturated lock_n", lock_n, 1);
    check("R5 saturated overspeed_n", overspeed_n, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule